// File: doc/BRIEF.md
# Accumulator Read-Out Packer

This block turns one wide signed accumulator value into one narrow destination word. It sits after a multiply-accumulate datapath and runs when a result is drained to storage. A mode input chooses one of two conversions. The raw mode keeps only the low destination bits, so an out-of-range value wraps and its sign can be lost. The scaled mode adds a half-LSB rounding term, shifts arithmetically right by a programmable amount (capped at one less than the accumulator width) and then clamps the result to the signed destination range.

The two modes agree for values that already fit the destination. For any value outside that range they give unrelated results. The rounding addition is one bit wider than the accumulator, so it cannot wrap. The result and a saturation flag are registered, and they appear one cycle after a valid input.

Top module: `acc_pack`

## Requirements
- R1: With `mode_rnd` = 0 (raw mode), `out_word` equals `acc_in[DST_W-1:0]`. The sign is discarded, so +256 gives 0x00 and +128 gives 0x80 at 8 bits.
- R2: With `mode_rnd` = 1 (scaled mode), a shift amount larger than ACC_W-1 behaves exactly like ACC_W-1.
- R3: In scaled mode, (1 << sh) >> 1 is added to the signed accumulator before the shift, using the capped shift sh. A shift of zero adds nothing. For example, 6 with shift 2 gives 2, -6 with shift 2 gives -1 (0xFF) and -7 with shift 2 gives -2 (0xFE).
- R4: In scaled mode, the rounded value is shifted arithmetically right by the capped shift, with the sign preserved. For example, -4660 with shift 8 gives -18.
- R5: In scaled mode, the shifted value is clamped to [-2^(DST_W-1), 2^(DST_W-1)-1]. At 8 bits, +256 and +128 both give 0x7F and -129 gives 0x80.
- R6: `out_sat` is 1 only when the clamp changed the value in scaled mode. It is always 0 in raw mode. An in-range value such as +127 gives the same word in both modes.
- R7: `out_valid` is `in_valid` delayed by exactly one cycle. `out_word` and `out_sat` update only in the cycle after `in_valid` is 1 and hold otherwise.
- R8: After a synchronous active-low reset, `out_valid`, `out_word` and `out_sat` are 0.
- R9: The rounding addition cannot overflow. The largest positive accumulator with shift 1 saturates to the positive limit, and with shift ACC_W-1 it gives +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| acc_in | input | ACC_W | Signed accumulator value |
| shift_in | input | SH_W | Right-shift amount for scaled mode |
| mode_rnd | input | 1 | 0 = raw low bits, 1 = round, shift, saturate |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | DST_W | Packed destination word |
| out_sat | output | 1 | Clamp changed the value (scaled mode only) |

## Verification
The datapath holds no state beyond the output register, so any internal error shows up on the very next `out_valid` cycle. A wrong shift cap shows first on shifts at or above the accumulator width. A rounding term that is missing or misplaced shows as a one-LSB error on half-way and negative inputs. An accumulator that is too narrow shows as a sign flip near the positive maximum. A capture enable that is wrong shows as `out_word` changing while `out_valid` is low.

// File: rtl/acc_pack_pkg.sv
// Shared types for the accumulator read-out packer.
// Assumes a single-bit mode selector on the top-level port.
package acc_pack_pkg;

    // Read-out conversion chosen per sample.
    typedef enum logic {
        PK_RAW    = 1'b0,
        PK_SCALED = 1'b1
    } pk_mode_e;

endpackage

// File: rtl/acc_pack_round_shift.sv
// Caps the shift, adds the half-LSB rounding term and shifts arithmetically.
// Assumes acc_i is signed ACC_W bits. Works at ACC_W+1 bits so the add cannot wrap.
module acc_pack_round_shift #(
    parameter int ACC_W = 24,
    parameter int SH_W  = 5,
    localparam int EXT_W = ACC_W + 1
) (
    input  logic [ACC_W-1:0]        acc_i,
    input  logic [SH_W-1:0]         shift_i,
    output logic signed [EXT_W-1:0] scaled_o
);

    localparam int MAX_SH = ACC_W - 1;

    logic [SH_W-1:0]         sh_eff;
    logic signed [EXT_W-1:0] acc_ext;
    logic signed [EXT_W-1:0] half_lsb;
    logic signed [EXT_W-1:0] rounded;

    // Cap the shift amount at ACC_W-1.
    always_comb begin
        if (int'(shift_i) > MAX_SH) sh_eff = SH_W'(MAX_SH);
        else                        sh_eff = shift_i;
    end

    // Sign-extend, add the rounding term, then shift arithmetically.
    always_comb begin
        acc_ext  = $signed({acc_i[ACC_W-1], acc_i});
        half_lsb = $signed((EXT_W'(1) << sh_eff) >> 1);
        rounded  = acc_ext + half_lsb;
        scaled_o = rounded >>> sh_eff;
    end

endmodule

// File: rtl/acc_pack_clamp.sv
// Clamps a signed value to the signed destination range and flags when it clamped.
// Assumes DST_W <= IN_W.
module acc_pack_clamp #(
    parameter int IN_W  = 25,
    parameter int DST_W = 8
) (
    input  logic signed [IN_W-1:0] val_i,
    output logic [DST_W-1:0]       word_o,
    output logic                   sat_o
);

    localparam logic signed [IN_W-1:0] HI = IN_W'((longint'(1) <<< (DST_W - 1)) - 1);
    localparam logic signed [IN_W-1:0] LO = -HI - IN_W'(1);

    // Compare against the limits and pick either the value or the limit.
    always_comb begin
        if (val_i > HI) begin
            word_o = HI[DST_W-1:0];
            sat_o  = 1'b1;
        end else if (val_i < LO) begin
            word_o = LO[DST_W-1:0];
            sat_o  = 1'b1;
        end else begin
            word_o = val_i[DST_W-1:0];
            sat_o  = 1'b0;
        end
    end

endmodule

// File: rtl/acc_pack.sv
// Accumulator read-out packer: raw low-bit slice or round/shift/saturate.
// Result and saturation flag are registered, giving one cycle of latency.
// Assumes DST_W <= ACC_W and that SH_W can hold ACC_W-1.
module acc_pack #(
    parameter int ACC_W = 24,
    parameter int DST_W = 8,
    parameter int SH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [SH_W-1:0]  shift_in,
    input  logic             mode_rnd,
    output logic             out_valid,
    output logic [DST_W-1:0] out_word,
    output logic             out_sat
);
    import acc_pack_pkg::*;

    localparam int EXT_W = ACC_W + 1;

    pk_mode_e                mode;
    logic signed [EXT_W-1:0] scaled;
    logic [DST_W-1:0]        clamp_word;
    logic                    clamp_sat;
    logic [DST_W-1:0]        next_word;
    logic                    next_sat;

    // Decode the mode pin.
    always_comb mode = pk_mode_e'(mode_rnd);

    acc_pack_round_shift #(.ACC_W(ACC_W), .SH_W(SH_W)) u_round_shift (
        .acc_i   (acc_in),
        .shift_i (shift_in),
        .scaled_o(scaled)
    );

    acc_pack_clamp #(.IN_W(EXT_W), .DST_W(DST_W)) u_clamp (
        .val_i (scaled),
        .word_o(clamp_word),
        .sat_o (clamp_sat)
    );

    // Select the result for the chosen mode.
    always_comb begin
        if (mode == PK_SCALED) begin
            next_word = clamp_word;
            next_sat  = clamp_sat;
        end else begin
            next_word = acc_in[DST_W-1:0];
            next_sat  = 1'b0;
        end
    end

    // Output register: capture on a valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_sat   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= next_word;
                out_sat  <= next_sat;
            end
        end
    end

endmodule

// File: rtl/acc_pack_chk.sv
// Port-level protocol and value checks for acc_pack, attached by bind.
module acc_pack_chk #(
    parameter int ACC_W = 24,
    parameter int DST_W = 8,
    parameter int SH_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [ACC_W-1:0] acc_in,
    input logic [SH_W-1:0]  shift_in,
    input logic             mode_rnd,
    input logic             out_valid,
    input logic [DST_W-1:0] out_word,
    input logic             out_sat
);

    localparam logic [DST_W-1:0] POS_LIM = {1'b0, {(DST_W-1){1'b1}}};
    localparam logic [DST_W-1:0] NEG_LIM = {1'b1, {(DST_W-1){1'b0}}};

    // R7: the output strobe follows the input strobe by one cycle.
    a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid) || !$past(rst_n));

    // R7: with no valid input, the outputs hold.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word) && $stable(out_sat));

    // R1: raw mode returns the low destination bits.
    a_r1_raw_slice: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mode_rnd |=> out_word == $past(acc_in[DST_W-1:0]));

    // R6: raw mode never raises the saturation flag.
    a_r6_raw_no_sat: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mode_rnd |=> !out_sat);

    // R5: a saturated result sits on one of the two limits.
    a_r5_sat_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat |-> (out_word == POS_LIM || out_word == NEG_LIM));

    // R3: with shift zero and an in-range value, scaled mode passes the value through.
    a_r3_zero_shift_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mode_rnd && shift_in == '0 &&
        (acc_in[ACC_W-1:DST_W-1] == '0 || acc_in[ACC_W-1:DST_W-1] == '1)
        |=> out_word == $past(acc_in[DST_W-1:0]) && !out_sat);

endmodule

bind acc_pack acc_pack_chk #(.ACC_W(ACC_W), .DST_W(DST_W), .SH_W(SH_W)) u_acc_pack_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .acc_in   (acc_in),
    .shift_in (shift_in),
    .mode_rnd (mode_rnd),
    .out_valid(out_valid),
    .out_word (out_word),
    .out_sat  (out_sat)
);

// File: tb/test_acc_pack.sv
`timescale 1ns/1ps
module test_acc_pack;

    localparam int ACC_W = 24;
    localparam int DST_W = 8;
    localparam int SH_W  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [ACC_W-1:0] acc_in = '0;
    logic [SH_W-1:0]  shift_in = '0;
    logic             mode_rnd = 1'b0;
    logic             out_valid;
    logic [DST_W-1:0] out_word;
    logic             out_sat;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [DST_W-1:0] exp_word_q[$];
    logic             exp_sat_q[$];
    string            exp_tag_q[$];

    acc_pack #(.ACC_W(ACC_W), .DST_W(DST_W), .SH_W(SH_W)) i_acc_pack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
        .shift_in(shift_in), .mode_rnd(mode_rnd), .out_valid(out_valid),
        .out_word(out_word), .out_sat(out_sat)
    );

    always #4 clk = ~clk;

    // Reference model written from the requirements.
    function automatic void model(input logic [ACC_W-1:0] acc, input int sh, input bit rnd,
                                  output logic [DST_W-1:0] w, output logic s);
        longint v, hi, lo;
        int     se;
        if (!rnd) begin
            w = acc[DST_W-1:0];
            s = 1'b0;
            return;
        end
        se = (sh > ACC_W - 1) ? ACC_W - 1 : sh;
        v  = longint'($signed(acc));
        v  = v + ((longint'(1) << se) >> 1);
        v  = v >>> se;
        hi = (longint'(1) << (DST_W - 1)) - 1;
        lo = -hi - 1;
        if (v > hi)      begin w = hi[DST_W-1:0]; s = 1'b1; end
        else if (v < lo) begin w = lo[DST_W-1:0]; s = 1'b1; end
        else             begin w = v[DST_W-1:0];  s = 1'b0; end
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Driver: present one sample for one cycle and queue its expected result.
    task automatic send(input logic [ACC_W-1:0] acc, input int sh, input bit rnd, input string tag);
        logic [DST_W-1:0] w;
        logic             s;
        model(acc, sh, rnd, w, s);
        @(negedge clk);
        in_valid = 1'b1;
        acc_in   = acc;
        shift_in = SH_W'(sh);
        mode_rnd = rnd;
        exp_word_q.push_back(w);
        exp_sat_q.push_back(s);
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compare each valid result against the queue front.
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid === 1'b1) begin
            if (exp_word_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R7: actual=unexpected out_valid expected=no result");
            end else begin
                string t;
                logic [DST_W-1:0] ew;
                logic es;
                t  = exp_tag_q.pop_front();
                ew = exp_word_q.pop_front();
                es = exp_sat_q.pop_front();
                check({t, " word"}, 32'(out_word), 32'(ew));
                check({t, " sat"},  32'(out_sat),  32'(es));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DST_W-1:0] held;
        repeat (3) @(negedge clk);
        // R8: reset state.
        check("R8 out_valid", 32'(out_valid), 0);
        check("R8 out_word",  32'(out_word),  0);
        check("R8 out_sat",   32'(out_sat),   0);
        rst_n = 1'b1;

        // R1: raw slices.
        send(24'h000100, 0, 0, "R1 +256 raw");
        send(24'h000080, 0, 0, "R1 +128 raw");
        send(24'hFFFF85, 5, 0, "R1 negative raw");
        // R5: saturation in scaled mode.
        send(24'h000100, 0, 1, "R5 +256 scaled");
        send(24'h000080, 0, 1, "R5 +128 scaled");
        send(24'hFFFF7F, 0, 1, "R5 -129 scaled");
        send(24'h800000, 0, 1, "R5 most negative");
        // R6: in-range values agree across modes.
        send(24'h00007F, 0, 1, "R6 +127 scaled");
        send(24'h00007F, 0, 0, "R6 +127 raw");
        send(24'hFFFF80, 0, 1, "R6 -128 scaled");
        // R3: rounding before the shift.
        send(24'h000006, 2, 1, "R3 6>>2");
        send(24'h000005, 2, 1, "R3 5>>2");
        send(24'hFFFFFA, 2, 1, "R3 -6>>2");
        send(24'hFFFFF9, 2, 1, "R3 -7>>2");
        // R4: arithmetic shift.
        send(24'h001234, 8, 1, "R4 +4660>>8");
        send(24'hFFEDCC, 8, 1, "R4 -4660>>8");
        // R2: shift cap.
        send(24'h400000, 23, 1, "R2 shift 23");
        send(24'h400000, 31, 1, "R2 shift 31");
        send(24'h800000, 24, 1, "R2 negative shift 24");
        // R9: wide rounding add.
        send(24'h7FFFFF, 1, 1, "R9 max shift 1");
        send(24'h7FFFFF, 31, 1, "R9 max shift capped");
        idle(3);

        // R7: outputs hold while in_valid is low, even when the inputs change.
        held = out_word;
        acc_in = 24'h00ABCD;
        mode_rnd = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R7 hold word", 32'(out_word), 32'(held));
        check("R7 valid low", 32'(out_valid), 0);
        check("R7 queue drained", 32'(exp_word_q.size()), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule